// File: doc/BRIEF.md
# Tiled 2D Address Sequencer

This block turns a small traversal descriptor into the stream of linear element addresses needed to read a two-dimensional buffer as a sequence of rectangular tiles. The buffer sits in memory one row after another. A tile is a rectangle of elements. Tile positions are set by an origin offset and by two nested stride-and-wrap loops, and each loop moves the tile along either the column axis or the row axis. The addresses come out tile by tile, so a consumer that writes the fetched elements to consecutive destination locations receives each tile as one contiguous run.

A one-cycle start pulse copies the descriptor into internal registers. The block checks the descriptor against the buffer bounds and then presents one address per cycle on a valid/ready handshake. When the last address has been accepted, it pulses done. A descriptor that would reach outside the buffer produces no addresses. Instead, done and a configuration-error flag pulse together.

The same block also covers a plain linear sweep: use a tile one full row wide and one row tall, and have a single loop step down the rows.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, addrValid, done and cfgErr are all low.
- R2: Inside a tile, elements come out row by row with the column varying fastest. Each address equals (tile origin row + element row) × bufCols + (tile origin column + element column).
- R3: Loop 0 is the inner loop and loop 1 is the outer loop. Every element of a tile is emitted before the tile origin moves, and loop 0 completes all its steps before loop 1 advances once.
- R4: A loop dimension selector of 0 adds counter × stride to the tile origin column. A selector of 1 adds counter × stride to the tile origin row. The offset (offCol, offRow) is the origin before any loop step.
- R5: A wrap value of 0 or 1 gives a single iteration of that loop, so both values produce the same address stream.
- R6: While addrValid is high and addrReady is low, addrValid stays high and addr holds its value in the next cycle, and no element is skipped.
- R7: done is high for exactly one cycle: the cycle after the last address is accepted. addrValid is low in that cycle.
- R8: The descriptor is rejected if tileCols or tileRows is 0, if bufCols exceeds MAX_COLS or bufRows exceeds MAX_ROWS, or if the furthest tile reaches past the buffer edge on either axis. The furthest reach is offset + Σ(wrap−1)×stride over the loops on that axis + tile size. A rejected descriptor emits no address, and done and cfgErr both go high two cycles after the start cycle.
- R9: The descriptor is sampled only by a start pulse while the block is idle. A start pulse, or a change of any descriptor input, during a run has no effect on that run.
- R10: A tile of bufCols×1 with loop 0 on dimension 1, stride 1 and wrap bufRows yields the addresses 0 to bufCols×bufRows−1 in increasing order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latches the descriptor and begins a run when idle |
| bufCols | input | CNT_W | Buffer width in elements |
| bufRows | input | CNT_W | Buffer height in elements |
| tileCols | input | CNT_W | Tile width in elements |
| tileRows | input | CNT_W | Tile height in elements |
| offCol | input | CNT_W | Column of the first tile origin |
| offRow | input | CNT_W | Row of the first tile origin |
| loop0Dim | input | 1 | Inner loop axis: 0 columns, 1 rows |
| loop0Stride | input | CNT_W | Inner loop step in elements |
| loop0Wrap | input | CNT_W | Inner loop iteration count (0 treated as 1) |
| loop1Dim | input | 1 | Outer loop axis: 0 columns, 1 rows |
| loop1Stride | input | CNT_W | Outer loop step in elements |
| loop1Wrap | input | CNT_W | Outer loop iteration count (0 treated as 1) |
| addrValid | output | 1 | Address output is valid |
| addrReady | input | 1 | Consumer accepts the address this cycle |
| addr | output | ADDR_W | Linear element address |
| done | output | 1 | One-cycle pulse at the end of a run |
| cfgErr | output | 1 | Pulses with done when the descriptor was rejected |

## Verification
The hardest case to reach from the ports is a descriptor whose two loops land on the same axis or cross each other, with the last tile ending exactly on the buffer edge. The randomly chosen cases spend the remaining room on each axis loop by loop, so some of them stop exactly at the edge and others stop one step short. Backpressure on every address, together with start pulses and descriptor changes injected in the middle of a run, shows whether the traversal state is frozen or disturbed. The directed cases cover the blocked-matrix read, the row-by-row sweep and a buffer 128 columns wide.

// File: rtl/tile_addr_gen_pkg.sv
package tile_addr_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIN   = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;  // capture descriptor
    logic clear;  // zero traversal counters
    logic step;   // advance one element
    logic emit;   // address is being presented
  } seqCtrl_t;

endpackage

// File: rtl/tile_addr_gen_ctrl.sv
module tile_addr_gen_ctrl
  import tile_addr_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     addrReady,
  input  logic     cfgBad,
  input  logic     lastElem,
  output seqCtrl_t ctrl,
  output logic     addrValid,
  output logic     done,
  output logic     cfgErr
);

  seqState_t state, stateNext;
  logic      errReg;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start) stateNext = ST_CHECK;
      ST_CHECK: stateNext = cfgBad ? ST_FIN : ST_RUN;
      ST_RUN:   if (addrReady && lastElem) stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_CHECK) errReg <= cfgBad;
    end
  end

  always_comb begin
    ctrl.latch = (state == ST_IDLE) && start;
    ctrl.clear = (state == ST_IDLE) && start;
    ctrl.emit  = (state == ST_RUN);
    ctrl.step  = (state == ST_RUN) && addrReady;
  end

  assign addrValid = (state == ST_RUN);
  assign done      = (state == ST_FIN);
  assign cfgErr    = (state == ST_FIN) && errReg;

  // R7: done never lasts more than one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: an error is only reported on the done cycle, with no address
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (done && !addrValid));

  // R9: a running traversal cannot be restarted
  p_run_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> (state == ST_RUN || state == ST_FIN));

endmodule

// File: rtl/tile_addr_gen_dp.sv
module tile_addr_gen_dp
  import tile_addr_gen_pkg::*;
#(
  parameter int MAX_COLS = 128,
  parameter int MAX_ROWS = 128,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 14,
  parameter int NLOOP    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqCtrl_t                    ctrl,
  input  logic [CNT_W-1:0]            bufCols,
  input  logic [CNT_W-1:0]            bufRows,
  input  logic [CNT_W-1:0]            tileCols,
  input  logic [CNT_W-1:0]            tileRows,
  input  logic [CNT_W-1:0]            offCol,
  input  logic [CNT_W-1:0]            offRow,
  input  logic [NLOOP-1:0]            loopDim,
  input  logic [NLOOP-1:0][CNT_W-1:0] loopStride,
  input  logic [NLOOP-1:0][CNT_W-1:0] loopWrap,
  output logic [ADDR_W-1:0]           addr,
  output logic                        cfgBad,
  output logic                        lastElem
);

  localparam int WIDE_W = 3 * CNT_W + 4;

  // latched descriptor
  logic [CNT_W-1:0]            cBufCols, cBufRows, cTileCols, cTileRows;
  logic [CNT_W-1:0]            cOffCol, cOffRow;
  logic [NLOOP-1:0]            cDim;
  logic [NLOOP-1:0][CNT_W-1:0] cStride, cWrap;

  // traversal counters
  logic [CNT_W-1:0]            elemCol, elemRow;
  logic [NLOOP-1:0][CNT_W-1:0] loopCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cBufCols  <= '0;
      cBufRows  <= '0;
      cTileCols <= '0;
      cTileRows <= '0;
      cOffCol   <= '0;
      cOffRow   <= '0;
      cDim      <= '0;
      cStride   <= '0;
      cWrap     <= '0;
    end else if (ctrl.latch) begin
      cBufCols  <= bufCols;
      cBufRows  <= bufRows;
      cTileCols <= tileCols;
      cTileRows <= tileRows;
      cOffCol   <= offCol;
      cOffRow   <= offRow;
      cDim      <= loopDim;
      cStride   <= loopStride;
      for (int g = 0; g < NLOOP; g++)
        cWrap[g] <= (loopWrap[g] == '0) ? CNT_W'(1) : loopWrap[g];
    end
  end

  // per-loop contributions and wrap detection
  logic [NLOOP-1:0][WIDE_W-1:0] colPart, rowPart, colReach, rowReach;
  logic [NLOOP-1:0]             loopAtEnd;
  logic [NLOOP:0]               carry;

  logic elemColEnd, elemRowEnd;
  assign elemColEnd = (elemCol == cTileCols - CNT_W'(1));
  assign elemRowEnd = (elemRow == cTileRows - CNT_W'(1));
  assign carry[0]   = elemColEnd && elemRowEnd;

  for (genvar g = 0; g < NLOOP; g++) begin : gLoop
    logic [WIDE_W-1:0] span, maxSpan;
    assign span    = WIDE_W'(loopCnt[g]) * WIDE_W'(cStride[g]);
    assign maxSpan = WIDE_W'(cWrap[g] - CNT_W'(1)) * WIDE_W'(cStride[g]);
    assign colPart[g]  = cDim[g] ? '0 : span;
    assign rowPart[g]  = cDim[g] ? span : '0;
    assign colReach[g] = cDim[g] ? '0 : maxSpan;
    assign rowReach[g] = cDim[g] ? maxSpan : '0;
    assign loopAtEnd[g] = (loopCnt[g] == cWrap[g] - CNT_W'(1));
    assign carry[g+1]   = carry[g] && loopAtEnd[g];

    always_ff @(posedge clk) begin
      if (!rstN || ctrl.clear)
        loopCnt[g] <= '0;
      else if (ctrl.step && carry[g])
        loopCnt[g] <= loopAtEnd[g] ? '0 : loopCnt[g] + CNT_W'(1);
    end

    // R3: a loop counter never leaves its wrap range while emitting
    p_loop_range_r3: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.emit |-> (loopCnt[g] < cWrap[g]));
  end

  assign lastElem = carry[NLOOP];

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      elemCol <= '0;
      elemRow <= '0;
    end else if (ctrl.step) begin
      elemCol <= elemColEnd ? '0 : elemCol + CNT_W'(1);
      if (elemColEnd)
        elemRow <= elemRowEnd ? '0 : elemRow + CNT_W'(1);
    end
  end

  // origin, address and bounds
  logic [WIDE_W-1:0] originCol, originRow, reachCol, reachRow, addrFull;

  always_comb begin
    originCol = WIDE_W'(cOffCol);
    originRow = WIDE_W'(cOffRow);
    reachCol  = WIDE_W'(cOffCol) + WIDE_W'(cTileCols);
    reachRow  = WIDE_W'(cOffRow) + WIDE_W'(cTileRows);
    for (int g = 0; g < NLOOP; g++) begin
      originCol = originCol + colPart[g];
      originRow = originRow + rowPart[g];
      reachCol  = reachCol + colReach[g];
      reachRow  = reachRow + rowReach[g];
    end
  end

  assign addrFull = (originRow + WIDE_W'(elemRow)) * WIDE_W'(cBufCols)
                  + originCol + WIDE_W'(elemCol);
  assign addr = addrFull[ADDR_W-1:0];

  assign cfgBad = (cTileCols == '0) || (cTileRows == '0)
               || (WIDE_W'(cBufCols) > WIDE_W'(MAX_COLS))
               || (WIDE_W'(cBufRows) > WIDE_W'(MAX_ROWS))
               || (reachCol > WIDE_W'(cBufCols))
               || (reachRow > WIDE_W'(cBufRows));

  // R2: every presented address lies inside the buffer
  p_addr_in_buffer_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.emit |-> (addrFull < WIDE_W'(cBufCols) * WIDE_W'(cBufRows)));

  // R6: stalled cycles leave the element counters untouched
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.emit && !ctrl.step) |=> ($stable(elemCol) && $stable(elemRow)));

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_gen_pkg::*;
#(
  parameter int MAX_COLS = 128,
  parameter int MAX_ROWS = 128,
  localparam int MAX_DIM = (MAX_COLS > MAX_ROWS) ? MAX_COLS : MAX_ROWS,
  localparam int CNT_W   = $clog2(MAX_DIM + 1),
  localparam int ADDR_W  = $clog2(MAX_COLS * MAX_ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  bufCols,
  input  logic [CNT_W-1:0]  bufRows,
  input  logic [CNT_W-1:0]  tileCols,
  input  logic [CNT_W-1:0]  tileRows,
  input  logic [CNT_W-1:0]  offCol,
  input  logic [CNT_W-1:0]  offRow,
  input  logic              loop0Dim,
  input  logic [CNT_W-1:0]  loop0Stride,
  input  logic [CNT_W-1:0]  loop0Wrap,
  input  logic              loop1Dim,
  input  logic [CNT_W-1:0]  loop1Stride,
  input  logic [CNT_W-1:0]  loop1Wrap,
  output logic              addrValid,
  input  logic              addrReady,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              cfgErr
);

  seqCtrl_t ctrl;
  logic     cfgBad, lastElem;

  tile_addr_gen_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .addrReady (addrReady),
    .cfgBad    (cfgBad),
    .lastElem  (lastElem),
    .ctrl      (ctrl),
    .addrValid (addrValid),
    .done      (done),
    .cfgErr    (cfgErr)
  );

  tile_addr_gen_dp #(
    .MAX_COLS (MAX_COLS),
    .MAX_ROWS (MAX_ROWS),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .NLOOP    (2)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .bufCols    (bufCols),
    .bufRows    (bufRows),
    .tileCols   (tileCols),
    .tileRows   (tileRows),
    .offCol     (offCol),
    .offRow     (offRow),
    .loopDim    ({loop1Dim, loop0Dim}),
    .loopStride ({loop1Stride, loop0Stride}),
    .loopWrap   ({loop1Wrap, loop0Wrap}),
    .addr       (addr),
    .cfgBad     (cfgBad),
    .lastElem   (lastElem)
  );

  // R6: a stalled address stays presented and unchanged
  p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> (addrValid && $stable(addr)));

endmodule

// File: tb/tb_tile_addr_gen.sv
module tb_tile_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int AW   = 14;
  localparam int MAXC = 128;
  localparam int MAXR = 128;
  localparam int MAXN = 16384;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] bufCols, bufRows, tileCols, tileRows, offCol, offRow;
  logic loop0Dim, loop1Dim;
  logic [CW-1:0] loop0Stride, loop0Wrap, loop1Stride, loop1Wrap;
  logic addrValid, addrReady, done, cfgErr;
  logic [AW-1:0] addr;

  int checks = 0;
  int failures = 0;
  int expAddr [MAXN];
  int expN;
  bit expErr;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_addr_gen dut (
    .clk(clk), .rstN(rstN), .start(start),
    .bufCols(bufCols), .bufRows(bufRows), .tileCols(tileCols), .tileRows(tileRows),
    .offCol(offCol), .offRow(offRow),
    .loop0Dim(loop0Dim), .loop0Stride(loop0Stride), .loop0Wrap(loop0Wrap),
    .loop1Dim(loop1Dim), .loop1Stride(loop1Stride), .loop1Wrap(loop1Wrap),
    .addrValid(addrValid), .addrReady(addrReady), .addr(addr),
    .done(done), .cfgErr(cfgErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int weff(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  // expected stream from the descriptor (R2, R3, R4, R5, R8)
  task automatic buildExpected();
    int w0, w1, s0, s1, rc, rr;
    w0 = weff(int'(loop0Wrap)); w1 = weff(int'(loop1Wrap));
    s0 = int'(loop0Stride); s1 = int'(loop1Stride);
    rc = int'(offCol) + int'(tileCols); rr = int'(offRow) + int'(tileRows);
    if (loop0Dim) rr += (w0-1)*s0; else rc += (w0-1)*s0;
    if (loop1Dim) rr += (w1-1)*s1; else rc += (w1-1)*s1;
    expErr = (tileCols == 0) || (tileRows == 0) || (int'(bufCols) > MAXC) ||
             (int'(bufRows) > MAXR) || (rc > int'(bufCols)) || (rr > int'(bufRows));
    expN = 0;
    if (!expErr) begin
      for (int i1 = 0; i1 < w1; i1++)
        for (int i0 = 0; i0 < w0; i0++) begin
          int oc, orow;
          oc = int'(offCol); orow = int'(offRow);
          if (loop0Dim) orow += i0*s0; else oc += i0*s0;
          if (loop1Dim) orow += i1*s1; else oc += i1*s1;
          for (int er = 0; er < int'(tileRows); er++)
            for (int ec = 0; ec < int'(tileCols); ec++) begin
              if (expN < MAXN) expAddr[expN] = (orow+er)*int'(bufCols) + oc + ec;
              expN++;
            end
        end
    end
  endtask

  task automatic setCfg(input int bc, input int br, input int tc, input int tr,
                        input int oc, input int orow,
                        input int d0, input int s0, input int w0,
                        input int d1, input int s1, input int w1);
    bufCols = CW'(bc); bufRows = CW'(br); tileCols = CW'(tc); tileRows = CW'(tr);
    offCol = CW'(oc); offRow = CW'(orow);
    loop0Dim = d0[0]; loop0Stride = CW'(s0); loop0Wrap = CW'(w0);
    loop1Dim = d1[0]; loop1Stride = CW'(s1); loop1Wrap = CW'(w1);
  endtask

  // runs one descriptor; chaos injects start pulses and input changes (R9)
  task automatic runPattern(input string tag, input bit chaos, input int readyPct);
    int idx, cyc;
    bit fin, lastTaken, prevHold;
    logic [AW-1:0] prevAddr;
    buildExpected();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    idx = 0; cyc = 0; fin = 0; lastTaken = 0; prevHold = 0; prevAddr = '0;
    while (!fin) begin
      if (lastTaken)
        check(done && !addrValid, "R7", {tag, " done in cycle after last accept"},
              {done, addrValid}, 2'b10);
      if (done) begin
        check(idx == expN, "R3", {tag, " element count"}, idx, expN);
        check(cfgErr == expErr, "R8", {tag, " cfgErr on done"}, cfgErr, expErr);
        if (expErr) check(cyc == 1, "R8", {tag, " reject latency"}, cyc, 1);
        fin = 1;
      end else begin
        if (prevHold)
          check(addrValid && addr == prevAddr, "R6", {tag, " hold under stall"},
                addr, prevAddr);
        if (addrValid) begin
          if (idx >= expN)
            check(0, "R2", {tag, " extra address"}, addr, -1);
          else if (addr != AW'(expAddr[idx]))
            check(0, "R2", {tag, " address"}, addr, expAddr[idx]);
          else checks++;
        end
        addrReady = (($urandom % 100) < readyPct);
        if (chaos && addrValid && (idx + 2 < expN) && (cyc % 5 == 2)) begin
          start = 1'b1;
          bufCols = CW'($urandom); tileCols = CW'($urandom); offRow = CW'($urandom);
          loop0Wrap = CW'($urandom); loop1Dim = ~loop1Dim;
        end else start = 1'b0;
        prevHold = addrValid && !addrReady;
        prevAddr = addr;
        lastTaken = 0;
        if (addrValid && addrReady) begin
          idx++;
          lastTaken = (idx == expN);
        end
      end
      @(negedge clk);
      cyc++;
      if (cyc > 60000) begin
        check(0, "R7", {tag, " watchdog on pattern"}, cyc, 60000);
        fin = 1;
      end
    end
    start = 1'b0;
    addrReady = 1'b0;
    check(!done && !addrValid, "R7", {tag, " done single cycle"}, done, 0);
  endtask

  task automatic randomCfg();
    int bc, br, tc, tr, oc, orow, spaceC, spaceR;
    int d [2]; int s [2]; int w [2];
    bc = 8 + $urandom % 57; br = 8 + $urandom % 57;
    tc = 1 + $urandom % 12; tr = 1 + $urandom % 12;
    oc = $urandom % (bc - tc + 1); orow = $urandom % (br - tr + 1);
    spaceC = bc - tc - oc; spaceR = br - tr - orow;
    for (int g = 0; g < 2; g++) begin
      int room, wmax;
      d[g] = $urandom % 2;
      s[g] = 1 + $urandom % 8;
      room = d[g] ? spaceR : spaceC;
      wmax = room / s[g] + 1;
      if (wmax > 8) wmax = 8;
      w[g] = $urandom % (wmax + 1);
      if ($urandom % 6 == 0) w[g] = wmax;
      if (d[g]) spaceR -= (weff(w[g]) - 1) * s[g]; else spaceC -= (weff(w[g]) - 1) * s[g];
    end
    if ($urandom % 8 == 0) w[1] = w[1] + 1;  // sometimes one step past the edge
    setCfg(bc, br, tc, tr, oc, orow, d[0], s[0], w[0], d[1], s[1], w[1]);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL R7 watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    addrReady = 1'b0;
    setCfg(64, 64, 16, 4, 0, 0, 0, 16, 4, 1, 4, 16);
    repeat (3) @(negedge clk);
    check(!addrValid && !done && !cfgErr, "R1", "outputs during reset",
          {addrValid, done, cfgErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!addrValid && !done && !cfgErr, "R1", "outputs after reset",
          {addrValid, done, cfgErr}, 0);

    // R3 R4: blocked read of a 64x64 buffer, 16x4 tiles
    setCfg(64, 64, 16, 4, 0, 0, 0, 16, 4, 1, 4, 16);
    runPattern("R3 blocked 64x64", 0, 80);
    // R9: same pattern with start pulses and input changes mid-run
    setCfg(64, 64, 16, 4, 0, 0, 0, 16, 4, 1, 4, 16);
    runPattern("R9 blocked with disturbance", 1, 70);
    // R10: linear sweep
    setCfg(64, 64, 64, 1, 0, 0, 1, 1, 64, 0, 0, 1);
    runPattern("R10 linear sweep", 0, 90);
    // R4: 128-column buffer
    setCfg(128, 32, 16, 4, 0, 0, 0, 16, 8, 1, 4, 8);
    runPattern("R4 wide buffer", 0, 85);
    // R4: offset with loop order swapped (rows inner)
    setCfg(40, 30, 5, 3, 2, 1, 1, 3, 9, 0, 6, 5);
    runPattern("R4 offset rows-inner", 0, 60);
    // R5: wrap 0 and wrap 1 on both loops
    setCfg(20, 20, 4, 4, 3, 3, 0, 7, 0, 1, 5, 1);
    runPattern("R5 wrap zero", 0, 50);
    setCfg(20, 20, 4, 4, 3, 3, 0, 7, 1, 1, 5, 0);
    runPattern("R5 wrap one", 0, 50);
    // R6: heavy backpressure
    setCfg(16, 16, 3, 2, 1, 1, 0, 4, 3, 1, 5, 3);
    runPattern("R6 heavy stall", 0, 20);
    // R8: edge fits exactly, then one past
    setCfg(32, 32, 8, 8, 0, 0, 0, 8, 4, 1, 8, 4);
    runPattern("R8 exact fit", 0, 75);
    setCfg(32, 32, 8, 8, 1, 0, 0, 8, 4, 1, 8, 4);
    runPattern("R8 column overflow", 0, 75);
    setCfg(32, 32, 8, 8, 0, 0, 0, 8, 4, 1, 8, 5);
    runPattern("R8 row overflow", 0, 75);
    setCfg(32, 32, 0, 8, 0, 0, 0, 8, 1, 1, 8, 1);
    runPattern("R8 zero tile", 0, 75);
    setCfg(200, 8, 4, 4, 0, 0, 0, 4, 1, 1, 4, 1);
    runPattern("R8 buffer too wide", 0, 75);

    for (int n = 0; n < 24; n++) begin
      randomCfg();
      runPattern("R2 random", (n % 3) == 0, 40 + ($urandom % 60));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule